// File: doc/BRIEF.md
# Static Memory Write Cycle Controller

This block turns one write request into the pin activity of a write to asynchronous static memory. A request carries an address, a data word, a transfer size of 8, 16 or 32 bits and a chip-select index. Once it is accepted, the controller drives the address and data, pulls the chosen chip select low, and then frames an active-low write enable inside that chip select and the active byte-lane strobes. Each edge of the framing has one clock of setup and one clock of hold.

Two 4-bit timing inputs shape the cycle. The delay value `cfg_delay` (call it D) inserts D clocks of chip-select-only time before the write pulse begins. The length value `cfg_length` (call it L) sets the write-pulse width to max(1, L − D) clocks. A mode input chooses how the byte lanes behave. In strobe mode they are byte strobes around a separate write enable. In direct mode they are the write enables themselves, and the dedicated write enable stays high. The timing inputs, the mode input and the request fields are all captured when the request is accepted.

Top module: `smw_write_ctrl`

## Requirements
- R1: During and after reset, every chip select, the write enable and every byte lane is high, and `busy` and `done` are low.
- R2: A request is accepted when `req_valid` is high in idle. From the first clock after acceptance through the hold clock, exactly one chip select is low: bit `req_cs` of `mem_cs_n`.
- R3: The active lanes are coded as follows. `req_size` 2 (or 3) is 32 bits and drives all four lanes low. `req_size` 1 is 16 bits and drives lanes 1:0 when address bit 1 is 0, and lanes 3:2 when it is 1. `req_size` 0 is 8 bits and drives only lane `req_addr[1:0]`.
- R4: With delay D, `mem_we_n` first goes low in clock D+2 after acceptance. Clock 1 is the first clock after the accepting edge.
- R5: `mem_we_n` stays low for max(1, L − D) consecutive clocks.
- R6: In strobe mode (`cfg_lane_we` = 0), the active lanes go low one clock before `mem_we_n` falls. They go high one clock after it rises.
- R7: The chip select goes low at least one clock before `mem_we_n` falls and goes high exactly one clock after it rises.
- R8: In direct mode (`cfg_lane_we` = 1), `mem_we_n` stays high for the whole cycle. The active lanes are low exactly in the clocks where the write pulse would be.
- R9: `mem_addr` and `mem_data` carry the accepted request from clock 1 and hold stable until the strobes release.
- R10: `done` is high for one clock, in clock D + max(1, L − D) + 3, which is the clock where all strobes are high again. `busy` is high in every clock from 1 up to that clock and low in it.
- R11: A request presented while `busy` is high is ignored. The cycle in progress and the idle state that follows it are unchanged.
- R12: Changes to the timing, mode or request inputs after acceptance do not alter the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request, taken only when idle |
| req_addr | input | 18 | Write address |
| req_data | input | 32 | Write data |
| req_size | input | 2 | 0 = 8 bit, 1 = 16 bit, 2/3 = 32 bit |
| req_cs | input | 2 | Chip-select index |
| cfg_length | input | 4 | Cycle length value L |
| cfg_delay | input | 4 | Write-enable delay value D |
| cfg_lane_we | input | 1 | 1 = lanes act as write enables |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| mem_addr | output | 18 | Memory address |
| mem_data | output | 32 | Memory write data |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lane_n | output | 4 | Active-low byte-lane strobes |

## Verification
On every clock, the assertions check the framing rules. At most one chip select is low. Write enable stays inside the chip select. The chip select and lanes lead the write-enable fall and trail its rise by one clock. Write enable stays high in direct mode. Address and data are stable while busy. `done` is a single clock outside `busy`. Only the directed scenarios can show the absolute placement, which depends on the captured timing values: the clock of the first write-enable edge, the pulse width including the clamp when L ≤ D, the lane pattern chosen by size and address, and the fact that requests and configuration changes made mid-cycle have no effect.

// File: rtl/smw_pkg.sv
`timescale 1ns/1ps
package smw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_PRE    = 3'd1,
    PH_LEAD   = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } smw_phase_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } smw_size_e;

endpackage

// File: rtl/smw_sequencer.sv
`timescale 1ns/1ps
module smw_sequencer
  import smw_pkg::*;
#(
  parameter int TIME_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TIME_W-1:0] delay,
  input  logic [TIME_W-1:0] length,
  output smw_phase_e        phase_q,
  output smw_phase_e        phase_nxt,
  output logic              last_clk
);

  logic [TIME_W-1:0] cnt_q, cnt_nxt;
  logic [TIME_W-1:0] width_m1_q, width_m1_c;

  // pulse width minus one, clamped so the pulse is at least one clock
  always_comb begin
    if (length > delay) width_m1_c = TIME_W'(length - delay - TIME_W'(1));
    else                width_m1_c = '0;
  end

  always_comb begin
    phase_nxt = phase_q;
    cnt_nxt   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          if (delay == '0) phase_nxt = PH_LEAD;
          else begin
            phase_nxt = PH_PRE;
            cnt_nxt   = TIME_W'(delay - TIME_W'(1));
          end
        end
      end
      PH_PRE: begin
        if (cnt_q == '0) phase_nxt = PH_LEAD;
        else             cnt_nxt   = cnt_q - TIME_W'(1);
      end
      PH_LEAD: begin
        phase_nxt = PH_STROBE;
        cnt_nxt   = width_m1_q;
      end
      PH_STROBE: begin
        if (cnt_q == '0) phase_nxt = PH_HOLD;
        else             cnt_nxt   = cnt_q - TIME_W'(1);
      end
      PH_HOLD: phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  assign last_clk = (phase_q == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      width_m1_q <= '0;
    end else begin
      phase_q <= phase_nxt;
      cnt_q   <= cnt_nxt;
      if (start && phase_q == PH_IDLE) width_m1_q <= width_m1_c;
    end
  end

  AST_LEAD_TO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LEAD) |=> (phase_q == PH_STROBE)); // R4
  AST_HOLD_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HOLD) |=> (phase_q == PH_IDLE)); // R10
  AST_NO_START_MID: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE && phase_q != PH_HOLD) |=> (phase_q != PH_IDLE)); // R11

endmodule

// File: rtl/smw_lane_decode.sv
`timescale 1ns/1ps
module smw_lane_decode
  import smw_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic [1:0]        size,
  input  logic [LANE_W-1:0] addr_lo,
  output logic [LANES-1:0]  mask
);

  localparam logic [LANES-1:0] ONE_LANE = LANES'(1);
  localparam logic [LANES-1:0] TWO_LANE = LANES'(3);

  always_comb begin
    unique case (size)
      2'(SZ_BYTE): mask = ONE_LANE << addr_lo;
      2'(SZ_HALF): mask = TWO_LANE << {addr_lo[LANE_W-1:1], 1'b0};
      default:     mask = '1;
    endcase
  end

endmodule

// File: rtl/smw_cs_decode.sv
`timescale 1ns/1ps
module smw_cs_decode #(
  parameter int NUM_CS = 4,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic [CS_W-1:0]   index,
  output logic [NUM_CS-1:0] onehot
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    assign onehot[g] = (index == CS_W'(g));
  end

endmodule

// File: rtl/smw_write_ctrl.sv
`timescale 1ns/1ps
module smw_write_ctrl
  import smw_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 4,
  parameter int TIME_W = 4,
  parameter int CS_W   = $clog2(NUM_CS),
  parameter int LANES  = DATA_W / 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        req_size,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [TIME_W-1:0] cfg_length,
  input  logic [TIME_W-1:0] cfg_delay,
  input  logic              cfg_lane_we,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_lane_n
);

  smw_phase_e        phase_q, phase_nxt;
  logic              last_clk;
  logic              accept;
  logic [LANES-1:0]  lane_dec, lane_q, lane_sel;
  logic [NUM_CS-1:0] cs_dec, cs_q, cs_sel;
  logic              mode_q, mode_sel;
  logic              lanes_on;

  assign accept = req_valid && (phase_q == PH_IDLE);

  smw_sequencer #(.TIME_W(TIME_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .delay     (cfg_delay),
    .length    (cfg_length),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .last_clk  (last_clk)
  );

  smw_lane_decode #(.LANES(LANES), .LANE_W(LANE_W)) u_lane (
    .size    (req_size),
    .addr_lo (req_addr[LANE_W-1:0]),
    .mask    (lane_dec)
  );

  smw_cs_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cs (
    .index  (req_cs),
    .onehot (cs_dec)
  );

  assign lane_sel = accept ? lane_dec    : lane_q;
  assign cs_sel   = accept ? cs_dec      : cs_q;
  assign mode_sel = accept ? cfg_lane_we : mode_q;

  // lanes framing: strobe mode leads/trails the pulse, direct mode is the pulse
  always_comb begin
    if (mode_sel) lanes_on = (phase_nxt == PH_STROBE);
    else          lanes_on = (phase_nxt == PH_LEAD) || (phase_nxt == PH_STROBE) ||
                             (phase_nxt == PH_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q     <= '0;
      cs_q       <= '0;
      mode_q     <= 1'b0;
      mem_addr   <= '0;
      mem_data   <= '0;
      mem_cs_n   <= '1;
      mem_we_n   <= 1'b1;
      mem_lane_n <= '1;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      if (accept) begin
        lane_q   <= lane_dec;
        cs_q     <= cs_dec;
        mode_q   <= cfg_lane_we;
        mem_addr <= req_addr;
        mem_data <= req_data;
      end
      mem_cs_n   <= (phase_nxt != PH_IDLE) ? ~cs_sel : '1;
      mem_we_n   <= !((phase_nxt == PH_STROBE) && !mode_sel);
      mem_lane_n <= lanes_on ? ~lane_sel : '1;
      busy       <= (phase_nxt != PH_IDLE);
      done       <= last_clk;
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n)); // R2
  AST_WE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_cs_n != '1)); // R7
  AST_CS_TRAIL: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_cs_n != '1)); // R7
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |=> (mem_cs_n == '1)); // R7
  AST_LANE_LEAD: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($past(mem_lane_n) != '1)); // R6
  AST_LANE_TRAIL: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_lane_n != '1)); // R6
  AST_DIRECT_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q) |-> mem_we_n); // R8
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> ($stable(mem_addr) && $stable(mem_data))); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && mem_cs_n == '1 && mem_lane_n == '1)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

endmodule

// File: tb/smw_write_ctrl_test.sv
`timescale 1ns/1ps
module smw_write_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [17:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [1:0]  req_size = '0;
  logic [1:0]  req_cs = '0;
  logic [3:0]  cfg_length = '0;
  logic [3:0]  cfg_delay = '0;
  logic        cfg_lane_we = 1'b0;
  logic        busy, done, mem_we_n;
  logic [17:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0]  mem_cs_n, mem_lane_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  smw_write_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_size(req_size), .req_cs(req_cs),
    .cfg_length(cfg_length), .cfg_delay(cfg_delay), .cfg_lane_we(cfg_lane_we),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_lanes(input logic [1:0] sz, input logic [17:0] a);
    if (sz == 2'd0) return 4'b0001 << a[1:0];
    if (sz == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  task automatic run_write(input logic [17:0] a, input logic [31:0] d,
                           input logic [1:0] sz, input logic [1:0] cs,
                           input int len, input int dly, input bit direct,
                           input bit interfere);
    int w, cs_first, cs_last, we_first, we_last, we_cnt;
    int ln_first, ln_last, ln_bad, bus_bad, bz_bad, done_idx, cs_bad;
    logic [3:0] lmask;
    w = (len > dly) ? len - dly : 1;
    lmask = exp_lanes(sz, a);
    cs_first = -1; cs_last = -1; we_first = -1; we_last = -1; we_cnt = 0;
    ln_first = -1; ln_last = -1; ln_bad = 0; bus_bad = 0; bz_bad = 0;
    done_idx = -1; cs_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_size = sz; req_cs = cs;
    cfg_length = 4'(len); cfg_delay = 4'(dly); cfg_lane_we = direct;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (i == 1) begin
        if (interfere) begin
          req_addr = ~a; req_data = ~d; req_size = 2'd0; req_cs = cs + 2'd1;
          cfg_length = 4'd15; cfg_delay = 4'd0; cfg_lane_we = ~direct;
        end else req_valid = 1'b0;
      end
      if (mem_cs_n != 4'hF) begin
        if (cs_first < 0) cs_first = i;
        cs_last = i;
        if (mem_cs_n != ~(4'b0001 << cs)) cs_bad++;
      end
      if (!mem_we_n) begin
        if (we_first < 0) we_first = i;
        we_last = i; we_cnt++;
      end
      if (mem_lane_n != 4'hF) begin
        if (ln_first < 0) ln_first = i;
        ln_last = i;
        if (mem_lane_n != ~lmask) ln_bad++;
      end
      if (done) begin
        done_idx = i;
        req_valid = 1'b0;
        chk(!busy, "R10", "busy at done", busy, 0);
        break;
      end
      if (!busy) bz_bad++;
      if (mem_addr != a || mem_data != d) bus_bad++;
    end
    chk(cs_first == 1 && cs_last == dly + w + 2, "R2/R7", "cs window end",
        cs_last, dly + w + 2);
    chk(cs_bad == 0, "R2", "cs index errors", cs_bad, 0);
    if (!direct) begin
      chk(we_first == dly + 2, "R4", "we first clock", we_first, dly + 2);
      chk(we_cnt == w && we_last == dly + w + 1, "R5", "we width", we_cnt, w);
      chk(ln_first == dly + 1 && ln_last == dly + w + 2, "R6", "lane lead clock",
          ln_first, dly + 1);
    end else begin
      chk(we_cnt == 0, "R8", "we low clocks", we_cnt, 0);
      chk(ln_first == dly + 2 && ln_last == dly + w + 1, "R8", "lane window start",
          ln_first, dly + 2);
    end
    chk(ln_bad == 0, "R3", "lane pattern errors", ln_bad, 0);
    chk(bus_bad == 0, "R9", "addr/data errors", bus_bad, 0);
    chk(done_idx == dly + w + 3 && bz_bad == 0, "R10", "done clock",
        done_idx, dly + w + 3);
    @(negedge clk);
    chk(!busy && mem_cs_n == 4'hF && mem_lane_n == 4'hF && mem_we_n,
        "R11", "idle after done", {busy, mem_cs_n}, 15);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_we_n && mem_lane_n == 4'hF, "R1", "strobes in reset",
        {mem_cs_n, mem_we_n, mem_lane_n}, 511);
    chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n == 4'hF && !busy, "R1", "after reset", mem_cs_n, 15);
  endtask

  task automatic test_word_min();     run_write(18'h00010, 32'hA5A5_0001, 2'd2, 2'd0, 0, 0, 1'b0, 1'b0); endtask
  task automatic test_half_upper();   run_write(18'h01236, 32'h1234_5678, 2'd1, 2'd2, 5, 2, 1'b0, 1'b0); endtask
  task automatic test_byte_clamp();   run_write(18'h3FFF1, 32'hDEAD_BEEF, 2'd0, 2'd1, 3, 15, 1'b0, 1'b0); endtask
  task automatic test_direct_byte();  run_write(18'h00003, 32'h0000_00C3, 2'd0, 2'd3, 4, 1, 1'b1, 1'b0); endtask
  task automatic test_direct_half();  run_write(18'h2AAA4, 32'h5555_AAAA, 2'd1, 2'd0, 7, 3, 1'b1, 1'b0); endtask
  task automatic test_long_pulse();   run_write(18'h10002, 32'h0F0F_0F0F, 2'd0, 2'd2, 15, 0, 1'b0, 1'b0); endtask
  task automatic test_busy_ignore();  run_write(18'h00C08, 32'hCAFE_F00D, 2'd2, 2'd1, 6, 2, 1'b0, 1'b1); endtask   // R11 R12
  task automatic test_cfg_frozen();   run_write(18'h0444E, 32'h8765_4321, 2'd1, 2'd3, 9, 4, 1'b1, 1'b1); endtask   // R12

  initial begin
    #(1_000_000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_word_min();
    test_half_upper();
    test_byte_clamp();
    test_direct_byte();
    test_direct_half();
    test_long_pulse();
    test_busy_ignore();
    test_cfg_frozen();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule